// File: doc/BRIEF.md
# Software-Loaded Variable-Page Translation Buffer

This block is a fully associative address translation buffer of 32 slots that software fills entirely by hand. A single register-style write port stages an effective page number and an attribute word (page size, cache-inhibit, write-through, global). A third write supplies the real page number and moves the staged page number, attributes and current address-space ID into the slot named by the index field of the control register. Each slot has its own page size: 1 KB, 4 KB, 16 KB, 512 KB or 8 MB.

A lookup presents an effective address. One clock later the block returns the translated real address and the slot's attributes, with hit or miss flags. An invalidate-all pulse clears the slots, and it can leave the top four slots untouched when those are reserved. A translation-disable mode passes addresses straight through, and the cache-inhibit output then takes a software-chosen default.

Top module: `sw_tlb`

## Requirements
- R1: After reset every slot is invalid, translation is disabled, the default cache-inhibit bit, the reserve bit, the slot index and the current ASID are 0, and all outputs are 0.
- R2: `rsp_vld_o` is 1 in exactly the cycle after a cycle with `req_i` high. `hit_o` and `miss_o` are 0 whenever `rsp_vld_o` is 0. `pa_o`, `ci_o` and `wt_o` hold their values when there is no request.
- R3: Write selects are 0 control, 1 effective page, 2 attributes, 3 real page, 4 ASID; codes 5 to 7 are ignored. A real-page write commits the staged effective page, the staged attributes and the current ASID into the slot given by control bits [12:8], and marks that slot valid. Effective-page and attribute writes on their own leave the table unchanged.
- R4: The attribute word carries the page size in bits [2:0]: 0 is 1 KB, 1 is 4 KB, 2 is 16 KB, 3 is 512 KB, 4 is 8 MB, and 5 to 7 act as 1 KB. A slot matches when the address bits above its page offset (bit 10, 12, 14, 19 or 23 upward) equal its effective page bits. Effective page bits below the offset are ignored.
- R5: On a hit `pa_o` is the slot's real page bits above the page offset joined with the lookup address bits below it. `ci_o` and `wt_o` are attribute bits 3 and 4.
- R6: With translation enabled, a lookup that matches no valid slot gives `miss_o`=1, `hit_o`=0, `pa_o`=0, `ci_o`=0 and `wt_o`=0. `hit_o` and `miss_o` are never 1 together.
- R7: When several slots match, the lowest-numbered slot supplies the result.
- R8: With control bit 2 (reserve) at 0, an invalidate-all clears the valid bit of every slot.
- R9: With the reserve bit at 1, an invalidate-all leaves slots 28 to 31 as they were and clears all the others.
- R10: Control bit 0 enables translation. While it is 0, a lookup returns `pa_o` equal to the lookup address, `ci_o` equal to control bit 1, and `wt_o`, `hit_o` and `miss_o` at 0.
- R11: A slot matches only when its attribute bit 5 (global) is 1 or its stored ASID equals the current ASID (bits [3:0] of the ASID write). ASID 0 is the supervisor space.
- R12: A lookup issued in the same cycle as a commit, an invalidate-all or a control write sees the state before that write. A commit in the same cycle as an invalidate-all leaves the committed slot valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 32 | Write data |
| inval_all_i | input | 1 | Invalidate-all command |
| req_i | input | 1 | Lookup request |
| va_i | input | 32 | Effective address to translate |
| rsp_vld_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | A valid slot matched |
| miss_o | output | 1 | No valid slot matched while translating |
| pa_o | output | 32 | Real address |
| ci_o | output | 1 | Cache-inhibit attribute |
| wt_o | output | 1 | Write-through attribute |

## Verification
Two pairs of functions can land on the same clock edge. A lookup can coincide with a slot commit, an invalidate or a control change. An invalidate-all can coincide with a real-page commit. The bench drives these combinations in one cycle on purpose: a real-page write together with a lookup of the page being loaded, an invalidate-all together with a commit, and a control write that enables translation together with a lookup. A reference model that applies the lookup to the state before the edge predicts each result, and the bench compares the model with the outputs on every clock.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_EPN  = 3'd1,
    SEL_ATTR = 3'd2,
    SEL_RPN  = 3'd3,
    SEL_ASID = 3'd4
  } wr_sel_e;

  localparam int CTRL_XLAT    = 0;
  localparam int CTRL_CIDEF   = 1;
  localparam int CTRL_RSV4    = 2;
  localparam int CTRL_IDX_LSB = 8;

  typedef struct packed {
    logic       glb;
    logic       wt;
    logic       ci;
    logic [2:0] psz;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);

  // page offset width per size code
  function automatic int unsigned off_bits(input logic [2:0] psz);
    case (psz)
      3'd1:    off_bits = 12;
      3'd2:    off_bits = 14;
      3'd3:    off_bits = 19;
      3'd4:    off_bits = 23;
      default: off_bits = 10;
    endcase
  endfunction

endpackage

// File: rtl/sw_tlb_regs.sv
module sw_tlb_regs
  import sw_tlb_pkg::*;
#(
  parameter int AW     = 32,
  parameter int IDX_W  = 5,
  parameter int ASID_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [AW-1:0]     wr_data_i,
  output logic              xlat_en_o,
  output logic              ci_def_o,
  output logic              rsv4_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ASID_W-1:0] asid_o,
  output logic [AW-1:0]     stg_epn_o,
  output attr_t             stg_attr_o,
  output logic              commit_o
);

  logic wr_ctrl, wr_epn, wr_attr, wr_asid;

  assign wr_ctrl  = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign wr_epn   = wr_en_i && (wr_sel_i == SEL_EPN);
  assign wr_attr  = wr_en_i && (wr_sel_i == SEL_ATTR);
  assign wr_asid  = wr_en_i && (wr_sel_i == SEL_ASID);
  assign commit_o = wr_en_i && (wr_sel_i == SEL_RPN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xlat_en_o <= 1'b0;
      ci_def_o  <= 1'b0;
      rsv4_o    <= 1'b0;
      idx_o     <= '0;
    end else if (wr_ctrl) begin
      xlat_en_o <= wr_data_i[CTRL_XLAT];
      ci_def_o  <= wr_data_i[CTRL_CIDEF];
      rsv4_o    <= wr_data_i[CTRL_RSV4];
      idx_o     <= wr_data_i[CTRL_IDX_LSB +: IDX_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) asid_o <= '0;
    else if (wr_asid) asid_o <= wr_data_i[ASID_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_epn_o  <= '0;
      stg_attr_o <= '0;
    end else begin
      if (wr_epn)  stg_epn_o  <= wr_data_i;
      if (wr_attr) stg_attr_o <= attr_t'(wr_data_i[ATTR_W-1:0]);
    end
  end

endmodule

// File: rtl/sw_tlb_array.sv
module sw_tlb_array
  import sw_tlb_pkg::*;
#(
  parameter int N      = 32,
  parameter int AW     = 32,
  parameter int IDX_W  = 5,
  parameter int ASID_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [AW-1:0]     epn_i,
  input  attr_t             attr_i,
  input  logic [AW-1:0]     rpn_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              inval_i,
  input  logic              rsv4_i,
  output logic [N-1:0]      valid_o,
  output logic [AW-1:0]     epn_o  [N],
  output logic [AW-1:0]     rpn_o  [N],
  output attr_t             attr_o [N],
  output logic [ASID_W-1:0] asid_o [N]
);

  localparam int RSV_LO = N - 4;

  for (genvar g = 0; g < N; g++) begin : g_ent
    localparam bit IS_RSV = (g >= RSV_LO);
    logic sel;
    assign sel = commit_i && (idx_i == IDX_W'(g));

    // commit outranks a same-cycle invalidate
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) valid_o[g] <= 1'b0;
      else if (sel) valid_o[g] <= 1'b1;
      else if (inval_i && !(rsv4_i && IS_RSV)) valid_o[g] <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        epn_o[g]  <= epn_i;
        rpn_o[g]  <= rpn_i;
        attr_o[g] <= attr_i;
        asid_o[g] <= asid_i;
      end
    end
  end

endmodule

// File: rtl/sw_tlb_match.sv
module sw_tlb_match
  import sw_tlb_pkg::*;
#(
  parameter int N      = 32,
  parameter int AW     = 32,
  parameter int IDX_W  = 5,
  parameter int ASID_W = 4
) (
  input  logic [AW-1:0]     va_i,
  input  logic [N-1:0]      valid_i,
  input  logic [AW-1:0]     epn_i  [N],
  input  logic [AW-1:0]     rpn_i  [N],
  input  attr_t             attr_i [N],
  input  logic [ASID_W-1:0] ent_asid_i [N],
  input  logic [ASID_W-1:0] cur_asid_i,
  output logic              hit_o,
  output logic [AW-1:0]     pa_o,
  output logic              ci_o,
  output logic              wt_o
);

  logic [N-1:0]  hit_vec;
  logic [AW-1:0] mask [N];
  logic [IDX_W-1:0] sel;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic asid_ok;
    assign mask[g]    = {AW{1'b1}} << off_bits(attr_i[g].psz);
    assign asid_ok    = attr_i[g].glb || (ent_asid_i[g] == cur_asid_i);
    assign hit_vec[g] = valid_i[g] && asid_ok && (((va_i ^ epn_i[g]) & mask[g]) == '0);
  end

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;
  assign pa_o  = (rpn_i[sel] & mask[sel]) | (va_i & ~mask[sel]);
  assign ci_o  = attr_i[sel].ci;
  assign wt_o  = attr_i[sel].wt;

endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
  import sw_tlb_pkg::*;
#(
  parameter int N_ENT  = 32,
  parameter int AW     = 32,
  parameter int ASID_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          inval_all_i,
  input  logic          req_i,
  input  logic [AW-1:0] va_i,
  output logic          rsp_vld_o,
  output logic          hit_o,
  output logic          miss_o,
  output logic [AW-1:0] pa_o,
  output logic          ci_o,
  output logic          wt_o
);

  localparam int IDX_W = $clog2(N_ENT);

  logic              xlat_en, ci_def, rsv4, commit;
  logic [IDX_W-1:0]  idx;
  logic [ASID_W-1:0] cur_asid;
  logic [AW-1:0]     stg_epn;
  attr_t             stg_attr;

  logic [N_ENT-1:0]  valid;
  logic [AW-1:0]     ent_epn  [N_ENT];
  logic [AW-1:0]     ent_rpn  [N_ENT];
  attr_t             ent_attr [N_ENT];
  logic [ASID_W-1:0] ent_asid [N_ENT];

  logic          m_hit, m_ci, m_wt;
  logic [AW-1:0] m_pa;

  sw_tlb_regs #(.AW(AW), .IDX_W(IDX_W), .ASID_W(ASID_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .xlat_en_o  (xlat_en),
    .ci_def_o   (ci_def),
    .rsv4_o     (rsv4),
    .idx_o      (idx),
    .asid_o     (cur_asid),
    .stg_epn_o  (stg_epn),
    .stg_attr_o (stg_attr),
    .commit_o   (commit)
  );

  sw_tlb_array #(.N(N_ENT), .AW(AW), .IDX_W(IDX_W), .ASID_W(ASID_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .idx_i    (idx),
    .epn_i    (stg_epn),
    .attr_i   (stg_attr),
    .rpn_i    (wr_data_i),
    .asid_i   (cur_asid),
    .inval_i  (inval_all_i),
    .rsv4_i   (rsv4),
    .valid_o  (valid),
    .epn_o    (ent_epn),
    .rpn_o    (ent_rpn),
    .attr_o   (ent_attr),
    .asid_o   (ent_asid)
  );

  sw_tlb_match #(.N(N_ENT), .AW(AW), .IDX_W(IDX_W), .ASID_W(ASID_W)) u_match (
    .va_i       (va_i),
    .valid_i    (valid),
    .epn_i      (ent_epn),
    .rpn_i      (ent_rpn),
    .attr_i     (ent_attr),
    .ent_asid_i (ent_asid),
    .cur_asid_i (cur_asid),
    .hit_o      (m_hit),
    .pa_o       (m_pa),
    .ci_o       (m_ci),
    .wt_o       (m_wt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_vld_o <= 1'b0;
      hit_o     <= 1'b0;
      miss_o    <= 1'b0;
      pa_o      <= '0;
      ci_o      <= 1'b0;
      wt_o      <= 1'b0;
    end else begin
      rsp_vld_o <= req_i;
      hit_o     <= 1'b0;
      miss_o    <= 1'b0;
      if (req_i) begin
        if (!xlat_en) begin
          pa_o <= va_i;
          ci_o <= ci_def;
          wt_o <= 1'b0;
        end else if (m_hit) begin
          hit_o <= 1'b1;
          pa_o  <= m_pa;
          ci_o  <= m_ci;
          wt_o  <= m_wt;
        end else begin
          miss_o <= 1'b1;
          pa_o   <= '0;
          ci_o   <= 1'b0;
          wt_o   <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sw_tlb_chk.sv
module sw_tlb_chk #(
  parameter int N     = 32,
  parameter int AW    = 32,
  parameter int IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [AW-1:0]    va_i,
  input logic             rsp_vld_o,
  input logic             hit_o,
  input logic             miss_o,
  input logic [AW-1:0]    pa_o,
  input logic             wt_o,
  input logic             inval_all_i,
  input logic             xlat_en_i,
  input logic             commit_i,
  input logic             rsv4_i,
  input logic [IDX_W-1:0] idx_i,
  input logic [N-1:0]     valid_i
);

  assert_rsp_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_vld_o);

  assert_no_rsp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_vld_o);

  assert_flags_need_vld_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o || miss_o) |-> rsp_vld_o);

  assert_hit_miss_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));

  assert_commit_sets_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> valid_i[$past(idx_i)]);

  assert_inval_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inval_all_i && !rsv4_i && !commit_i) |=> (valid_i == '0));

  assert_rsv_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inval_all_i && rsv4_i && !commit_i) |=> $stable(valid_i[N-1 -: 4]));

  assert_bypass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !xlat_en_i) |=> (pa_o == $past(va_i)) && !hit_o && !miss_o && !wt_o);

endmodule

bind sw_tlb sw_tlb_chk #(.N(N_ENT), .AW(AW), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .va_i        (va_i),
  .rsp_vld_o   (rsp_vld_o),
  .hit_o       (hit_o),
  .miss_o      (miss_o),
  .pa_o        (pa_o),
  .wt_o        (wt_o),
  .inval_all_i (inval_all_i),
  .xlat_en_i   (xlat_en),
  .commit_i    (commit),
  .rsv4_i      (rsv4),
  .idx_i       (idx),
  .valid_i     (valid)
);

// File: tb/sw_tlb_tb_top.sv
`timescale 1ns/1ps
module sw_tlb_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        inval_all_i = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] va_i = '0;
  logic        rsp_vld_o, hit_o, miss_o, ci_o, wt_o;
  logic [31:0] pa_o;

  int n_vec = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  sw_tlb dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .inval_all_i(inval_all_i), .req_i(req_i), .va_i(va_i),
    .rsp_vld_o(rsp_vld_o), .hit_o(hit_o), .miss_o(miss_o), .pa_o(pa_o),
    .ci_o(ci_o), .wt_o(wt_o)
  );

  // reference model state
  bit        m_xlat, m_cidef, m_rsv4;
  int        m_idx;
  bit [3:0]  m_asid;
  bit [31:0] st_epn;
  bit [5:0]  st_attr;
  bit        m_v    [32];
  bit [31:0] m_epn  [32];
  bit [31:0] m_rpn  [32];
  bit [5:0]  m_attr [32];
  bit [3:0]  m_tag  [32];
  bit        e_vld, e_hit, e_miss, e_ci, e_wt;
  bit [31:0] e_pa;

  function automatic bit [31:0] page_mask(bit [2:0] psz);
    int off;
    case (psz)
      3'd1: off = 12;
      3'd2: off = 14;
      3'd3: off = 19;
      3'd4: off = 23;
      default: off = 10;
    endcase
    return 32'hFFFF_FFFF << off;
  endfunction

  task automatic model_edge(bit we, bit [2:0] sel, bit [31:0] d, bit inv, bit rq, bit [31:0] va);
    int found;
    bit [31:0] mk;
    e_vld = rq; e_hit = 0; e_miss = 0;
    if (rq) begin
      if (!m_xlat) begin
        e_pa = va; e_ci = m_cidef; e_wt = 0;
      end else begin
        found = -1;
        for (int i = 0; i < 32; i++) begin
          mk = page_mask(m_attr[i][2:0]);
          if (found < 0 && m_v[i] && (m_attr[i][5] || m_tag[i] == m_asid) &&
              ((va & mk) == (m_epn[i] & mk))) found = i;
        end
        if (found >= 0) begin
          mk = page_mask(m_attr[found][2:0]);
          e_hit = 1; e_pa = (m_rpn[found] & mk) | (va & ~mk);
          e_ci = m_attr[found][3]; e_wt = m_attr[found][4];
        end else begin
          e_miss = 1; e_pa = 0; e_ci = 0; e_wt = 0;
        end
      end
    end
    if (inv) for (int i = 0; i < 32; i++) if (!(m_rsv4 && i >= 28)) m_v[i] = 0;
    if (we) begin
      case (sel)
        3'd0: begin m_xlat = d[0]; m_cidef = d[1]; m_rsv4 = d[2]; m_idx = int'(d[12:8]); end
        3'd1: st_epn = d;
        3'd2: st_attr = d[5:0];
        3'd3: begin
          m_v[m_idx] = 1; m_epn[m_idx] = st_epn; m_rpn[m_idx] = d;
          m_attr[m_idx] = st_attr; m_tag[m_idx] = m_asid;
        end
        3'd4: m_asid = d[3:0];
        default: ;
      endcase
    end
  endtask

  task automatic compare(string tag);
    n_vec++;
    if ({rsp_vld_o, hit_o, miss_o, ci_o, wt_o, pa_o} !== {e_vld, e_hit, e_miss, e_ci, e_wt, e_pa}) begin
      n_err++;
      $display("FAIL %s vld,hit,miss,ci,wt,pa act=%b%b%b%b%b %h exp=%b%b%b%b%b %h", tag,
               rsp_vld_o, hit_o, miss_o, ci_o, wt_o, pa_o, e_vld, e_hit, e_miss, e_ci, e_wt, e_pa);
    end
  endtask

  task automatic step(bit we, bit [2:0] sel, bit [31:0] d, bit inv, bit rq, bit [31:0] va, string tag);
    wr_en_i = we; wr_sel_i = sel; wr_data_i = d; inval_all_i = inv; req_i = rq; va_i = va;
    @(posedge clk_i);
    model_edge(we, sel, d, inv, rq, va);
    @(negedge clk_i);
    wr_en_i = 0; inval_all_i = 0; req_i = 0;
    compare(tag);
  endtask

  task automatic wr(bit [2:0] sel, bit [31:0] d, string tag);
    step(1, sel, d, 0, 0, 0, tag);
  endtask

  task automatic look(bit [31:0] va, string tag);
    step(0, 0, 0, 0, 1, va, tag);
  endtask

  task automatic load(int idx, bit [31:0] epn, bit [5:0] attr, bit [31:0] rpn, string tag);
    wr(3'd0, 32'h1 | (idx << 8), tag);
    wr(3'd1, epn, tag);
    wr(3'd2, {26'd0, attr}, tag);
    wr(3'd3, rpn, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");                                 // reset outputs
    look(32'h1234_5678, "R1");                     // disabled after reset
    wr(3'd0, 32'h1, "R1");
    look(32'h1234_5678, "R1");                     // all slots invalid

    // R3: staging alone does not commit
    wr(3'd1, 32'h0010_0000, "R3");
    wr(3'd2, 32'h9, "R3");
    look(32'h0010_0123, "R3");
    wr(3'd7, 32'hFFFF_FFFF, "R3");                 // ignored select
    wr(3'd3, 32'h8020_0000, "R3");
    look(32'h0010_0abc, "R3");
    look(32'h0010_1000, "R4");

    // R4/R5 page sizes
    load(1, 32'h0200_0400, 6'h0, 32'h0300_0800, "R4");
    look(32'h0200_07ff, "R5");
    look(32'h0200_0800, "R4");
    load(2, 32'h0400_4000, 6'h2, 32'h0500_0000, "R4");
    look(32'h0400_7ffc, "R5");
    load(3, 32'h0608_1234, 6'h3, 32'h0700_0000, "R4");
    look(32'h060F_FFF0, "R4");
    look(32'h0610_0000, "R4");
    load(4, 32'h1080_0000, 6'h14, 32'h2000_1234, "R5");
    look(32'h10FF_FFFF, "R5");
    load(5, 32'h3000_0000, 6'h7, 32'h3100_0000, "R4");
    look(32'h3000_0123, "R4");
    look(32'h3000_0400, "R6");

    // R7 priority
    load(6, 32'h0010_0000, 6'h4, 32'h4000_0000, "R7");
    look(32'h0010_0abc, "R7");
    look(32'h0020_0000, "R7");

    // R11 address-space tags
    wr(3'd4, 32'h3, "R11");
    look(32'h0010_0abc, "R11");
    load(8, 32'h5000_0000, 6'h20, 32'h5100_0000, "R11");
    load(9, 32'h5200_0000, 6'h0, 32'h5300_0000, "R11");
    look(32'h5000_0010, "R11");
    look(32'h5200_0000, "R11");
    wr(3'd4, 32'h0, "R11");
    look(32'h5200_0000, "R11");
    look(32'h5000_0010, "R11");
    look(32'h0010_0abc, "R11");

    // R12 lookup together with commit
    wr(3'd0, 32'h1 | (10 << 8), "R12");
    wr(3'd1, 32'h6000_0000, "R12");
    wr(3'd2, 32'h0, "R12");
    step(1, 3'd3, 32'h6100_0000, 0, 1, 32'h6000_0004, "R12");
    look(32'h6000_0004, "R12");

    // R8 invalidate all, lookup in same cycle sees old table
    step(0, 0, 0, 1, 1, 32'h0010_0abc, "R12");
    look(32'h0010_0abc, "R8");
    look(32'h5000_0010, "R8");

    // R9 reserved slots
    load(29, 32'h7000_0000, 6'h0, 32'h7100_0000, "R9");
    load(2, 32'h7200_0000, 6'h0, 32'h7300_0000, "R9");
    wr(3'd0, 32'h5 | (2 << 8), "R9");
    step(0, 0, 0, 1, 0, 0, "R9");
    look(32'h7000_0000, "R9");
    look(32'h7200_0000, "R9");

    // R12 commit with invalidate in the same cycle
    wr(3'd0, 32'h1 | (3 << 8), "R12");
    wr(3'd1, 32'h7400_0000, "R12");
    wr(3'd2, 32'h0, "R12");
    step(1, 3'd3, 32'h7500_0000, 1, 0, 0, "R12");
    look(32'h7400_0008, "R12");
    look(32'h7000_0000, "R8");

    // R10 bypass with cache-inhibit default
    wr(3'd0, 32'h2, "R10");
    look(32'h7400_0008, "R10");
    step(1, 3'd0, 32'h1, 0, 1, 32'hABCD_0000, "R12");
    look(32'h7400_0008, "R10");
    step(0, 0, 0, 0, 0, 0, "R2");                  // idle cycle
    step(0, 0, 0, 0, 0, 0, "R2");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

endmodule